// File: doc/BRIEF.md
# Programmable Display Timing Generator

The block produces the raster timing for one video output. Software sets the horizontal and vertical geometry as absolute counter positions: where sync ends, where the active window starts and ends, and the total period. From these the block derives horizontal sync, vertical sync, data-enable and the zero-based pixel and line position inside the active area. Each of sync and data-enable has its own polarity, and a separate output carries the requested pixel-clock inversion.

All settings are written through a small synchronous write port into a shadow set. The shadow set takes effect only after a commit write, and only at the boundary into the next frame, so a frame never mixes old and new settings. The timing is routed to one of four encoder paths, and at most one path is ever enabled. The output colour depth is 24-bit RGB unless 30-bit output is requested, the instance has the 10-bit capability, and the chosen path can carry it.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, no path is enabled, every path's hsync and vsync are 1 and de is 0, pixel position outputs and out_mode_o are 0, and dclk_inv_o is 0.
- R2: The horizontal count runs from 0 to period-1, so one line lasts period cycles. Hsync is active for counts below sync_end. Address 0 holds sync_end in bits [11:0] and period in bits [27:16].
- R3: The vertical count advances once per line and wraps after its period. Vsync is active for lines below its sync_end. Address 2 uses the same layout as address 0, counted in lines.
- R4: Data-enable is active when the horizontal count lies in [act_start, act_end) and the line lies in the same vertical window. Addresses 1 (horizontal) and 3 (vertical) hold act_start in bits [11:0] and act_end in bits [27:16]. pix_x_o and pix_y_o give the count minus act_start while data-enable is active, and 0 otherwise.
- R5: Polarity word (address 4): bit 0 = 1 makes hsync active high, bit 1 = 1 makes vsync active high, and bit 2 = 1 makes data-enable active low. A cleared bit gives the opposite sense.
- R6: dclk_inv_o follows bit 3 of the active polarity word.
- R7: Writes to addresses 0 to 6 change only the shadow set. The outputs keep the active settings until a commit is written (address 7, bit 0 = 1).
- R8: A committed shadow set becomes active exactly at the next frame start. Every cycle before that boundary still shows the old settings.
- R9: The path register (address 5) keeps only the lowest set bit of the written value. Bit 0 is HDMI, bit 1 eDP, bit 2 parallel RGB/LVDS and bit 3 MIPI. path_en_o has at most one bit set.
- R10: Every disabled path holds hsync, vsync and de at the inactive level of the active polarity word.
- R11: out_mode_o is 15 (30-bit RGB) only when the mode register (address 6) holds 15, parameter TEN_BIT is 1, and the enabled path is HDMI or eDP. Otherwise it is 0 (24-bit RGB).
- R12: The commit flag clears itself at the transfer. Later shadow writes stay inactive until a new commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| hsync_o | output | 4 | Horizontal sync per path |
| vsync_o | output | 4 | Vertical sync per path |
| de_o | output | 4 | Data-enable per path |
| pix_x_o | output | 12 | Pixel offset inside the active line |
| pix_y_o | output | 12 | Line offset inside the active frame |
| path_en_o | output | 4 | One-hot encoder path enable |
| out_mode_o | output | 4 | Effective output colour mode |
| dclk_inv_o | output | 1 | Pixel clock inversion request |

## Verification
The hardest case to reach from the ports is a commit that arrives mid-frame. The new set must wait for the exact frame boundary and must not leak into the remaining cycles of the old frame. The bench aligns to a frame start by watching the enabled path's vsync onset and issues the commit one cycle later. It then checks path_en_o on the last cycle of the old frame and again on the first cycle of the new one. A second instance built without the 10-bit capability shares the write port, so every table frame also shows its mode falling back to 24-bit.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  parameter int unsigned CW     = 12;
  parameter int unsigned AW     = 3;
  parameter int unsigned DW     = 32;
  parameter int unsigned NPATH  = 4;
  parameter int unsigned MW     = 4;
  parameter int unsigned PW     = 4;
  localparam int unsigned HI_LSB = 16;

  typedef logic [CW-1:0] cnt_t;

  typedef struct packed {
    cnt_t sync_end;
    cnt_t act_start;
    cnt_t act_end;
    cnt_t period;
  } axis_cfg_t;

  typedef struct packed {
    axis_cfg_t          h;
    axis_cfg_t          v;
    logic [PW-1:0]      pol;
    logic [NPATH-1:0]   path;
    logic [MW-1:0]      mode;
  } disp_cfg_t;

  typedef enum logic [AW-1:0] {
    A_HTIM   = 3'd0,
    A_HWIN   = 3'd1,
    A_VTIM   = 3'd2,
    A_VWIN   = 3'd3,
    A_POL    = 3'd4,
    A_PATH   = 3'd5,
    A_MODE   = 3'd6,
    A_COMMIT = 3'd7
  } reg_addr_e;

  localparam int unsigned POL_HS = 0;
  localparam int unsigned POL_VS = 1;
  localparam int unsigned POL_DE = 2;
  localparam int unsigned POL_CK = 3;

  localparam int unsigned PATH_HDMI = 0;
  localparam int unsigned PATH_EDP  = 1;

  localparam logic [MW-1:0] MODE_RGB24 = MW'(0);
  localparam logic [MW-1:0] MODE_RGB30 = MW'(15);

  function automatic logic [NPATH-1:0] keep_lowest(input logic [NPATH-1:0] req);
    keep_lowest = req & (~req + NPATH'(1));
  endfunction
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter disp_cfg_t RST_CFG = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          frame_wrap_i,
  output disp_cfg_t     act_o,
  output logic          pending_o
);
  disp_cfg_t shd_q, act_q;
  logic      pend_q;
  logic      commit_wr;

  assign commit_wr = wr_en_i && (reg_addr_e'(wr_addr_i) == A_COMMIT) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= RST_CFG;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        A_HTIM: begin
          shd_q.h.sync_end <= wr_data_i[CW-1:0];
          shd_q.h.period   <= wr_data_i[HI_LSB +: CW];
        end
        A_HWIN: begin
          shd_q.h.act_start <= wr_data_i[CW-1:0];
          shd_q.h.act_end   <= wr_data_i[HI_LSB +: CW];
        end
        A_VTIM: begin
          shd_q.v.sync_end <= wr_data_i[CW-1:0];
          shd_q.v.period   <= wr_data_i[HI_LSB +: CW];
        end
        A_VWIN: begin
          shd_q.v.act_start <= wr_data_i[CW-1:0];
          shd_q.v.act_end   <= wr_data_i[HI_LSB +: CW];
        end
        A_POL:  shd_q.pol  <= wr_data_i[PW-1:0];
        A_PATH: shd_q.path <= keep_lowest(wr_data_i[NPATH-1:0]);
        A_MODE: shd_q.mode <= wr_data_i[MW-1:0];
        default: ;
      endcase
    end
  end

  // commit wins over the clear so a commit on the wrap edge is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pend_q <= 1'b0;
    else if (commit_wr)    pend_q <= 1'b1;
    else if (frame_wrap_i) pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     act_q <= RST_CFG;
    else if (frame_wrap_i && pend_q) act_q <= shd_q;
  end

  assign act_o     = act_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis
  import dtg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      step_i,
  input  axis_cfg_t cfg_i,
  output logic      last_o,
  output logic      sync_o,
  output logic      act_o,
  output cnt_t      pos_o
);
  cnt_t        cnt_q;
  logic [CW:0] cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + (CW+1)'(1);
  // a zero period keeps the count parked at 0
  assign last_o  = cnt_inc >= {1'b0, cfg_i.period};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_inc[CW-1:0];
  end

  assign sync_o = cnt_q < cfg_i.sync_end;
  assign act_o  = (cnt_q >= cfg_i.act_start) && (cnt_q < cfg_i.act_end);
  assign pos_o  = act_o ? cnt_q - cfg_i.act_start : '0;
endmodule

// File: rtl/dtg_out_stage.sv
module dtg_out_stage
  import dtg_pkg::*;
#(
  parameter bit TEN_BIT = 1'b1
) (
  input  logic [PW-1:0]    pol_i,
  input  logic [NPATH-1:0] path_i,
  input  logic [MW-1:0]    mode_i,
  input  logic             hs_i,
  input  logic             vs_i,
  input  logic             de_i,
  output logic [NPATH-1:0] hsync_o,
  output logic [NPATH-1:0] vsync_o,
  output logic [NPATH-1:0] de_o,
  output logic [NPATH-1:0] path_en_o,
  output logic [MW-1:0]    mode_o,
  output logic             dclk_inv_o
);
  logic deep_ok;

  for (genvar i = 0; i < NPATH; i++) begin : g_path
    assign hsync_o[i] = (path_i[i] && hs_i) ?  pol_i[POL_HS] : ~pol_i[POL_HS];
    assign vsync_o[i] = (path_i[i] && vs_i) ?  pol_i[POL_VS] : ~pol_i[POL_VS];
    assign de_o[i]    = (path_i[i] && de_i) ? ~pol_i[POL_DE] :  pol_i[POL_DE];
  end

  if (TEN_BIT) begin : g_deep
    assign deep_ok = path_i[PATH_HDMI] | path_i[PATH_EDP];
  end else begin : g_flat
    assign deep_ok = 1'b0;
  end

  assign mode_o     = (mode_i == MODE_RGB30 && deep_ok) ? MODE_RGB30 : MODE_RGB24;
  assign path_en_o  = path_i;
  assign dclk_inv_o = pol_i[POL_CK];
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter bit        TEN_BIT = 1'b1,
  parameter disp_cfg_t RST_CFG = '{
    h: '{sync_end: 12'd2, act_start: 12'd4, act_end: 12'd12, period: 12'd16},
    v: '{sync_end: 12'd1, act_start: 12'd2, act_end: 12'd6,  period: 12'd8},
    pol: 4'd0, path: 4'd0, mode: 4'd0}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [NPATH-1:0] hsync_o,
  output logic [NPATH-1:0] vsync_o,
  output logic [NPATH-1:0] de_o,
  output logic [CW-1:0]    pix_x_o,
  output logic [CW-1:0]    pix_y_o,
  output logic [NPATH-1:0] path_en_o,
  output logic [MW-1:0]    out_mode_o,
  output logic             dclk_inv_o
);
  disp_cfg_t act_cfg;
  logic      pending;
  logic      h_last, v_last, h_sync, v_sync, h_act, v_act;
  logic      frame_wrap, de_raw;
  cnt_t      h_pos, v_pos;

  assign frame_wrap = h_last & v_last;

  dtg_regs #(.RST_CFG(RST_CFG)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .frame_wrap_i(frame_wrap),
    .act_o       (act_cfg),
    .pending_o   (pending)
  );

  dtg_axis u_hax (
    .clk_i, .rst_ni,
    .step_i(1'b1),
    .cfg_i (act_cfg.h),
    .last_o(h_last),
    .sync_o(h_sync),
    .act_o (h_act),
    .pos_o (h_pos)
  );

  dtg_axis u_vax (
    .clk_i, .rst_ni,
    .step_i(h_last),
    .cfg_i (act_cfg.v),
    .last_o(v_last),
    .sync_o(v_sync),
    .act_o (v_act),
    .pos_o (v_pos)
  );

  assign de_raw  = h_act & v_act;
  assign pix_x_o = de_raw ? h_pos : '0;
  assign pix_y_o = de_raw ? v_pos : '0;

  dtg_out_stage #(.TEN_BIT(TEN_BIT)) u_out (
    .pol_i     (act_cfg.pol),
    .path_i    (act_cfg.path),
    .mode_i    (act_cfg.mode),
    .hs_i      (h_sync),
    .vs_i      (v_sync),
    .de_i      (de_raw),
    .hsync_o, .vsync_o, .de_o, .path_en_o,
    .mode_o    (out_mode_o),
    .dclk_inv_o
  );
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker
  import dtg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [AW-1:0]    wr_addr_i,
  input logic [DW-1:0]    wr_data_i,
  input logic [NPATH-1:0] hsync_o,
  input logic [NPATH-1:0] vsync_o,
  input logic [NPATH-1:0] de_o,
  input logic [CW-1:0]    pix_x_o,
  input logic [NPATH-1:0] path_en_o,
  input logic [MW-1:0]    out_mode_o,
  input disp_cfg_t        act_cfg,
  input logic             pending,
  input logic             frame_wrap,
  input logic             h_last,
  input logic             de_raw,
  input cnt_t             v_pos
);
  logic commit_seen;
  assign commit_seen = wr_en_i && (wr_addr_i == A_COMMIT) && wr_data_i[0];

  a_r9_path_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(path_en_o));

  a_r8_swap_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_cfg) |-> $past(frame_wrap));

  a_r12_flag_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending && frame_wrap && !commit_seen) |=> !pending);

  a_r11_deep_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_mode_o != MODE_RGB24) |->
      (out_mode_o == MODE_RGB30 && (path_en_o[PATH_HDMI] || path_en_o[PATH_EDP])));

  a_r4_x_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_raw && $past(de_raw) && !$past(h_last)) |-> pix_x_o == $past(pix_x_o) + CW'(1));

  a_r3_line_steps_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(v_pos) |-> $past(h_last));

  for (genvar i = 0; i < NPATH; i++) begin : g_idle
    a_r10_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !path_en_o[i] |-> (hsync_o[i] == !act_cfg.pol[POL_HS] &&
                         vsync_o[i] == !act_cfg.pol[POL_VS] &&
                         de_o[i]    ==  act_cfg.pol[POL_DE]));
  end
endmodule

bind disp_timing_gen dtg_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
  .pix_x_o(pix_x_o), .path_en_o(path_en_o), .out_mode_o(out_mode_o),
  .act_cfg(act_cfg), .pending(pending), .frame_wrap(frame_wrap),
  .h_last(h_last), .de_raw(de_raw), .v_pos(v_pos)
);

// File: tb/disp_timing_gen_bench.sv
module disp_timing_gen_bench;
  import dtg_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;

  logic [NPATH-1:0] hsync, vsync, de, path_en;
  logic [CW-1:0]    pix_x, pix_y;
  logic [MW-1:0]    out_mode;
  logic             dclk_inv;

  logic [NPATH-1:0] n_hs, n_vs, n_de, n_path;
  logic [CW-1:0]    n_x, n_y;
  logic [MW-1:0]    n_mode;
  logic             n_ck;

  disp_timing_gen u_disp_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .pix_x_o(pix_x), .pix_y_o(pix_y),
    .path_en_o(path_en), .out_mode_o(out_mode), .dclk_inv_o(dclk_inv));

  disp_timing_gen #(.TEN_BIT(1'b0)) u_disp_timing_gen_nc (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .hsync_o(n_hs), .vsync_o(n_vs), .de_o(n_de), .pix_x_o(n_x), .pix_y_o(n_y),
    .path_en_o(n_path), .out_mode_o(n_mode), .dclk_inv_o(n_ck));

  int errs = 0;
  int checks = 0;

  // hse hst hend hper | vse vst vend vper | pol path mode
  localparam int NV = 5;
  localparam int TBL [NV][11] = '{
    '{2, 4, 12, 16, 1, 2, 6, 8,  4'b0001, 4'b0001, 15},
    '{3, 5, 15, 18, 2, 3, 7, 9,  4'b0110, 4'b0110, 15},
    '{1, 2, 10, 12, 1, 2, 5, 6,  4'b1011, 4'b1100, 15},
    '{4, 6, 20, 22, 1, 3, 8, 10, 4'b0000, 4'b1000, 0},
    '{2, 2, 8,  8,  1, 1, 4, 4,  4'b0011, 4'b0001, 3}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge, returns at a negedge
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = a[AW-1:0]; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_onset(input int idx, input bit lvl, output bit found);
    bit prev, cur;
    prev = (vsync[idx] == lvl);
    found = 1'b0;
    for (int n = 0; n < 2000 && !found; n++) begin
      @(negedge clk);
      cur = (vsync[idx] == lvl);
      if (cur && !prev) found = 1'b1;
      prev = cur;
    end
  endtask

  task automatic run_table();
    int old_len = 16 * 8;
    for (int e = 0; e < NV; e++) begin
      int hse = TBL[e][0], hst = TBL[e][1], hen = TBL[e][2], hpr = TBL[e][3];
      int vse = TBL[e][4], vst = TBL[e][5], ven = TBL[e][6], vpr = TBL[e][7];
      logic [3:0] pol = TBL[e][8][3:0];
      logic [3:0] req = TBL[e][9][3:0];
      int mode = TBL[e][10];
      int pidx = -1;
      logic [3:0] ep;
      int emode;
      bit found;
      bit b_hs = 0, b_vs = 0, b_de = 0, b_xy = 0, b_pe = 0, b_md = 0, b_ck = 0, b_nc = 0;
      int a_hs = 0, x_hs = 0, a_vs = 0, x_vs = 0, a_de = 0, x_de = 0, a_xy = 0, x_xy = 0;
      for (int i = 3; i >= 0; i--) if (req[i]) pidx = i;
      ep = (pidx < 0) ? 4'b0 : 4'(1 << pidx);
      emode = (mode == 15 && (pidx == 0 || pidx == 1)) ? 15 : 0;
      wr(A_HTIM, (hpr << 16) | hse);
      wr(A_HWIN, (hen << 16) | hst);
      wr(A_VTIM, (vpr << 16) | vse);
      wr(A_VWIN, (ven << 16) | vst);
      wr(A_POL, pol);
      wr(A_PATH, req);
      wr(A_MODE, mode);
      wr(A_COMMIT, 1);
      repeat (old_len + 2) @(negedge clk);
      wait_onset(pidx, pol[POL_VS], found);
      chk(found, "R3 vsync onset", found, 1);
      for (int v = 0; v < vpr; v++) begin
        for (int h = 0; h < hpr; h++) begin
          bit hs = h < hse, vs = v < vse;
          bit dd = (h >= hst && h < hen) && (v >= vst && v < ven);
          logic [3:0] xh, xv, xd;
          int xx = dd ? h - hst : 0, xy = dd ? v - vst : 0;
          for (int i = 0; i < 4; i++) begin
            xh[i] = (ep[i] && hs) ?  pol[POL_HS] : !pol[POL_HS];
            xv[i] = (ep[i] && vs) ?  pol[POL_VS] : !pol[POL_VS];
            xd[i] = (ep[i] && dd) ? !pol[POL_DE] :  pol[POL_DE];
          end
          if (hsync !== xh && !b_hs) begin b_hs = 1; a_hs = hsync; x_hs = xh; end
          if (vsync !== xv && !b_vs) begin b_vs = 1; a_vs = vsync; x_vs = xv; end
          if (de !== xd && !b_de) begin b_de = 1; a_de = de; x_de = xd; end
          if ((pix_x !== CW'(xx) || pix_y !== CW'(xy)) && !b_xy) begin
            b_xy = 1; a_xy = (pix_y << 16) | pix_x; x_xy = (xy << 16) | xx;
          end
          if (path_en !== ep) b_pe = 1;
          if (out_mode !== MW'(emode)) b_md = 1;
          if (dclk_inv !== pol[POL_CK]) b_ck = 1;
          if (n_mode !== MODE_RGB24) b_nc = 1;
          @(negedge clk);
        end
      end
      chk(!b_hs, "R2 R5 hsync", a_hs, x_hs);
      chk(!b_vs, "R3 R5 vsync", a_vs, x_vs);
      chk(!b_de, "R4 R5 R10 de", a_de, x_de);
      chk(!b_xy, "R4 pixel position", a_xy, x_xy);
      chk(!b_pe, "R9 path enable", path_en, ep);
      chk(!b_md, "R11 out mode", out_mode, emode);
      chk(!b_ck, "R6 dclk inversion", dclk_inv, pol[POL_CK]);
      chk(!b_nc, "R11 no 10-bit capability", n_mode, 0);
      old_len = hpr * vpr;
    end
  endtask

  task automatic run_directed();
    bit found;
    bit bad;
    // active now: last table entry, frame 8x4, pol 0011, path HDMI
    wr(A_PATH, 4'b0100);
    repeat (80) @(negedge clk);
    chk(path_en == 4'b0001, "R7 shadow write without commit", path_en, 1);

    wait_onset(0, 1'b1, found);
    chk(found, "R8 frame align", found, 1);
    wr(A_COMMIT, 1);
    repeat (30) @(negedge clk);
    chk(path_en == 4'b0001, "R8 last cycle of old frame", path_en, 1);
    @(negedge clk);
    chk(path_en == 4'b0100, "R8 first cycle of new frame", path_en, 4);

    wr(A_PATH, 4'b0001);
    repeat (80) @(negedge clk);
    chk(path_en == 4'b0100, "R12 flag cleared after transfer", path_en, 4);

    wr(A_PATH, 4'b0000);
    wr(A_COMMIT, 1);
    repeat (80) @(negedge clk);
    chk(path_en == 4'b0000, "R9 no path", path_en, 0);
    bad = 0;
    for (int n = 0; n < 40; n++) begin
      if (hsync !== 4'b0 || vsync !== 4'b0 || de !== 4'b0) bad = 1;
      @(negedge clk);
    end
    chk(!bad, "R10 idle paths inactive", {hsync, vsync, de}, 0);

    wr(A_PATH, 4'b1111);
    wr(A_COMMIT, 1);
    repeat (80) @(negedge clk);
    chk(path_en == 4'b0001, "R9 lowest bit kept", path_en, 1);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(path_en == 4'b0, "R1 reset path", path_en, 0);
        chk(hsync == 4'hF && vsync == 4'hF && de == 4'h0, "R1 reset levels",
            {hsync, vsync, de}, 12'hFF0);
        chk(pix_x == '0 && pix_y == '0 && out_mode == '0 && !dclk_inv, "R1 reset data",
            {pix_y, pix_x}, 0);
        run_table();
        run_directed();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule